// File: doc/BRIEF.md
# Shorthand Pin Mode Register Bank

This block keeps one 32-bit configuration word for each of a set of I/O pins (64 by default). Software-facing logic upstream issues three kinds of write command, each naming a pin. A full write stores an arbitrary 32-bit word. A compact write carries a 9-bit operand that a prefix decoder expands into a complete mode word, which selects the input style and the high and low drive strengths. A level write loads an 8-bit converter level and forces the converter-output mode bits.

Each accepted command updates its pin's word on one clock edge. A combinational read port returns the stored word of any pin. If several commands name the same pin in the same cycle, a fixed priority picks one of them. Commands that name different pins all take effect together.

Top module: `pinmode_bank`

## Requirements
- R1: After reset is asserted, every pin word reads 0x00000000.
- R2: A full write stores its 32-bit data in the named pin's word. The read port shows the new word from the clock edge that accepts the write.
- R3: A compact operand 000HHHLLL yields a word with operand bits [5:0] in word bits [13:8] and zeros everywhere else. The operand 0 therefore yields the all-zero word.
- R4: A compact operand 001HHHLLL yields 0x00060000 | (op[5:0] << 8). A compact operand 010HHHLLL yields 0x000C0000 | (op[5:0] << 8).
- R5: Compact operands 01110xxxx yield 0x00082D00, and operands 01111xxxx yield 0x000E4900. The low four operand bits have no effect on either.
- R6: A compact operand with op[8]=1 yields 0x00140080 | (op[7:0] << 8).
- R7: A level write replaces the whole word with 0x00160000 | (level << 8).
- R8: A compact operand with prefix 0110 (op[8:5]=0110) is reserved and leaves the named pin's word unchanged.
- R9: When commands collide on one pin in one cycle, the full write wins over the compact write, and the compact write wins over the level write.
- R10: Commands naming different pins in the same cycle all take effect. Words of pins that no command names keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_we | input | 1 | Full-word write strobe |
| full_pin | input | 6 | Pin index for the full write |
| full_data | input | 32 | Word for the full write |
| short_we | input | 1 | Compact write strobe |
| short_pin | input | 6 | Pin index for the compact write |
| short_op | input | 9 | Compact operand |
| dac_we | input | 1 | Level write strobe |
| dac_pin | input | 6 | Pin index for the level write |
| dac_level | input | 8 | Converter level |
| rd_pin | input | 6 | Pin index for the read port |
| rd_data | output | 32 | Stored word of pin rd_pin |

## Verification
The assertions assume that every write strobe and the pin index and operand that go with it are known and stable around each rising clock edge. They also assume that rst_n is the only thing that disturbs the stored words. The stimulus changes inputs only on falling edges and drops the strobes after a single cycle. It reads a word only after the accepting edge, and it runs its collision cases with all three strobes driven in the same cycle so that the priority checks see the intended overlap.

// File: rtl/pinmode_pkg.sv
package pinmode_pkg;
  localparam int WORD_W   = 32;
  localparam int OP_W     = 9;
  localparam int LEVEL_W  = 8;
  localparam int LEVEL_LO = 8;
  localparam int MODE_LO  = 17;
  localparam int DRV_LO   = 8;

  typedef logic [WORD_W-1:0] mode_word_t;

  localparam logic [3:0] IN_LOGIC   = 4'b0000;
  localparam logic [3:0] IN_SCHMITT = 4'b0011;
  localparam logic [3:0] IN_COMPARE = 4'b0110;
  localparam logic [3:0] IN_LATCH   = 4'b0100;
  localparam logic [3:0] IN_FOLLOW  = 4'b0111;

  localparam logic [8:0] DRV_LATCH  = 9'b000101101;
  localparam logic [8:0] DRV_FOLLOW = 9'b001001001;

  localparam logic [4:0] DAC_SEL_SHORT = 5'b10100;
  localparam logic [4:0] DAC_SEL_FULL  = 5'b10110;
  localparam logic [1:0] DAC_AUX_SHORT = 2'b10;

  function automatic mode_word_t mk_drive(input logic [3:0] inmode, input logic [8:0] drv);
    mode_word_t w;
    w = '0;
    w[MODE_LO +: 4] = inmode;
    w[DRV_LO +: 9]  = drv;
    return w;
  endfunction
endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pm_short_expand.sv
module pm_short_expand
  import pinmode_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output mode_word_t      word,
  output logic            valid
);
  always_comb begin
    word  = '0;
    valid = 1'b1;
    casez (op)
      9'b1????????: begin
        word[DRV_LO + LEVEL_W +: 5] = DAC_SEL_SHORT;
        word[LEVEL_LO +: LEVEL_W]   = op[LEVEL_W-1:0];
        word[7:6]                   = DAC_AUX_SHORT;
      end
      9'b000??????: word = mk_drive(IN_LOGIC,   {3'b000, op[5:0]});
      9'b001??????: word = mk_drive(IN_SCHMITT, {3'b000, op[5:0]});
      9'b010??????: word = mk_drive(IN_COMPARE, {3'b000, op[5:0]});
      9'b01110????: word = mk_drive(IN_LATCH,   DRV_LATCH);
      9'b01111????: word = mk_drive(IN_FOLLOW,  DRV_FOLLOW);
      default:      valid = 1'b0;
    endcase
  end

  always_comb begin
    if (!$isunknown(op)) begin
      // R3
      top_zero_chk: assert (word[31:21] == '0);
      // R6
      dac_aux_chk: assert (!op[8] || (word[7:6] == 2'b10 && word[15:8] == op[7:0]));
      // R8
      reserved_chk: assert ((op[8:5] == 4'b0110) == !valid);
    end
  end
endmodule

// File: rtl/pm_dac_form.sv
module pm_dac_form
  import pinmode_pkg::*;
(
  input  logic [LEVEL_W-1:0] level,
  output mode_word_t         word
);
  always_comb begin
    word = '0;
    word[DRV_LO + LEVEL_W +: 5] = DAC_SEL_FULL;
    word[LEVEL_LO +: LEVEL_W]   = level;
  end

  always_comb begin
    if (!$isunknown(level)) begin
      // R7
      dac_clean_chk: assert (word[7:0] == '0 && word[31:21] == '0 && word[20:16] == 5'b10110);
    end
  end
endmodule

// File: rtl/pm_reg_file.sv
module pm_reg_file
  import pinmode_pkg::*;
#(
  parameter int NPINS = 64,
  localparam int PIN_W = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             full_we,
  input  logic [PIN_W-1:0] full_pin,
  input  mode_word_t       full_word,
  input  logic             short_we,
  input  logic [PIN_W-1:0] short_pin,
  input  mode_word_t       short_word,
  input  logic             dac_we,
  input  logic [PIN_W-1:0] dac_pin,
  input  mode_word_t       dac_word,
  input  logic [PIN_W-1:0] rd_pin,
  output mode_word_t       rd_data
);
  mode_word_t mem_q [NPINS];
  mode_word_t nxt_d [NPINS];
  logic [NPINS-1:0] en_d;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic hit_full, hit_short, hit_dac;
    assign hit_full  = full_we  && (full_pin  == PIN_W'(g));
    assign hit_short = short_we && (short_pin == PIN_W'(g));
    assign hit_dac   = dac_we   && (dac_pin   == PIN_W'(g));
    assign en_d[g]   = hit_full || hit_short || hit_dac;
    assign nxt_d[g]  = hit_full  ? full_word  :
                       hit_short ? short_word : dac_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPINS; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < NPINS; i++) begin
        if (en_d[i]) mem_q[i] <= nxt_d[i];
      end
    end
  end

  assign rd_data = mem_q[rd_pin];

  // R2
  full_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_we |=> (mem_q[$past(full_pin)] == $past(full_word)));

  // R9
  short_over_dac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (short_we && dac_we && short_pin == dac_pin && !(full_we && full_pin == short_pin))
    |=> (mem_q[$past(short_pin)] == $past(short_word)));

  // R10
  dac_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_we && !(full_we && full_pin == dac_pin) && !(short_we && short_pin == dac_pin))
    |=> (mem_q[$past(dac_pin)] == $past(dac_word)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_we && !short_we && !dac_we) |=> $stable(rd_pin) -> $stable(rd_data));
endmodule

// File: rtl/pinmode_bank.sv
module pinmode_bank
  import pinmode_pkg::*;
#(
  parameter int NPINS = 64,
  localparam int PIN_W = $clog2(NPINS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               full_we,
  input  logic [PIN_W-1:0]   full_pin,
  input  logic [WORD_W-1:0]  full_data,
  input  logic               short_we,
  input  logic [PIN_W-1:0]   short_pin,
  input  logic [OP_W-1:0]    short_op,
  input  logic               dac_we,
  input  logic [PIN_W-1:0]   dac_pin,
  input  logic [LEVEL_W-1:0] dac_level,
  input  logic [PIN_W-1:0]   rd_pin,
  output logic [WORD_W-1:0]  rd_data
);
  logic       rst_n_int;
  mode_word_t short_word;
  logic       short_ok;
  mode_word_t dac_word;
  logic       short_en;

  pm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pm_short_expand u_expand (
    .op    (short_op),
    .word  (short_word),
    .valid (short_ok)
  );

  pm_dac_form u_dac (
    .level (dac_level),
    .word  (dac_word)
  );

  assign short_en = short_we && short_ok;

  pm_reg_file #(.NPINS(NPINS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .full_we    (full_we),
    .full_pin   (full_pin),
    .full_word  (full_data),
    .short_we   (short_en),
    .short_pin  (short_pin),
    .short_word (short_word),
    .dac_we     (dac_we),
    .dac_pin    (dac_pin),
    .dac_word   (dac_word),
    .rd_pin     (rd_pin),
    .rd_data    (rd_data)
  );
endmodule

// File: tb/pinmode_bank_bench.sv
module pinmode_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        full_we, short_we, dac_we;
  logic [5:0]  full_pin, short_pin, dac_pin, rd_pin;
  logic [31:0] full_data;
  logic [8:0]  short_op;
  logic [7:0]  dac_level;
  logic [31:0] rd_data;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinmode_bank u_pinmode_bank (
    .clk(clk), .rst_n(rst_n),
    .full_we(full_we), .full_pin(full_pin), .full_data(full_data),
    .short_we(short_we), .short_pin(short_pin), .short_op(short_op),
    .dac_we(dac_we), .dac_pin(dac_pin), .dac_level(dac_level),
    .rd_pin(rd_pin), .rd_data(rd_data)
  );

  // kind(2) pin(6) operand(32) expected(32); kind 0 full, 1 compact, 2 level
  localparam logic [71:0] VEC [NV] = '{
    {2'd0, 6'd5,  32'hDEADBEEF, 32'hDEADBEEF}, // R2
    {2'd1, 6'd5,  32'h000,      32'h00000000}, // R3
    {2'd1, 6'd6,  32'h02B,      32'h00002B00}, // R3
    {2'd1, 6'd7,  32'h078,      32'h00063800}, // R4
    {2'd1, 6'd8,  32'h095,      32'h000C1500}, // R4
    {2'd1, 6'd9,  32'h0EA,      32'h00082D00}, // R5
    {2'd1, 6'd10, 32'h0F5,      32'h000E4900}, // R5
    {2'd1, 6'd11, 32'h0E0,      32'h00082D00}, // R5
    {2'd1, 6'd12, 32'h1A5,      32'h0014A580}, // R6
    {2'd1, 6'd63, 32'h100,      32'h00140080}, // R6
    {2'd0, 6'd0,  32'hFFFFFFFF, 32'hFFFFFFFF}, // R2
    {2'd2, 6'd0,  32'h07E,      32'h00167E00}, // R7
    {2'd2, 6'd63, 32'h0FF,      32'h0016FF00}, // R7
    {2'd0, 6'd20, 32'h12345678, 32'h12345678}, // R2
    {2'd1, 6'd20, 32'h0C3,      32'h12345678}  // R8
  };

  task automatic check(input string req, input logic [5:0] pin, input logic [31:0] exp);
    rd_pin = pin;
    #1;
    tests++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s pin %0d: got %h expected %h", req, pin, rd_data, exp);
    end
  endtask

  task automatic idle();
    full_we = 0; short_we = 0; dac_we = 0;
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle();
    full_pin = 0; short_pin = 0; dac_pin = 0; rd_pin = 0;
    full_data = 0; short_op = 0; dac_level = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1", 6'd0, 32'h0);
    check("R1", 6'd31, 32'h0);
    check("R1", 6'd63, 32'h0);

    for (int v = 0; v < NV; v++) begin
      case (VEC[v][71:70])
        2'd0: begin full_we = 1; full_pin = VEC[v][69:64]; full_data = VEC[v][63:32]; end
        2'd1: begin short_we = 1; short_pin = VEC[v][69:64]; short_op = VEC[v][40:32]; end
        default: begin dac_we = 1; dac_pin = VEC[v][69:64]; dac_level = VEC[v][39:32]; end
      endcase
      @(negedge clk);
      idle();
      check($sformatf("vector %0d", v), VEC[v][69:64], VEC[v][31:0]);
    end

    // R9 all three on one pin: full wins
    full_we = 1; full_pin = 6'd3; full_data = 32'hA5A5A5A5;
    short_we = 1; short_pin = 6'd3; short_op = 9'h1FF;
    dac_we = 1; dac_pin = 6'd3; dac_level = 8'h44;
    @(negedge clk); idle();
    check("R9", 6'd3, 32'hA5A5A5A5);

    // R9 compact over level
    short_we = 1; short_pin = 6'd4; short_op = 9'h03F;
    dac_we = 1; dac_pin = 6'd4; dac_level = 8'h99;
    @(negedge clk); idle();
    check("R9", 6'd4, 32'h00003F00);

    // R10 three distinct pins at once
    full_we = 1; full_pin = 6'd40; full_data = 32'h00000011;
    short_we = 1; short_pin = 6'd41; short_op = 9'h100;
    dac_we = 1; dac_pin = 6'd42; dac_level = 8'h01;
    @(negedge clk); idle();
    check("R10", 6'd40, 32'h00000011);
    check("R10", 6'd41, 32'h00140080);
    check("R10", 6'd42, 32'h00160100);
    check("R10", 6'd5, 32'h00000000);
    check("R10", 6'd20, 32'h12345678);

    // R1 reset during operation clears everything
    rst_n = 0;
    @(negedge clk);
    check("R1", 6'd63, 32'h0);
    check("R1", 6'd40, 32'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule